// File: doc/BRIEF.md
# Triggered Look-Back Window Capture Buffer

The block keeps a free-running history of its 32-bit input stream. It stores one word on every clock edge into a circular delay memory, so the most recent 256 samples are always held. When a trigger pulse arrives, the block copies a short run of consecutive samples out of that history into an event data FIFO. The run is between 3 and 15 words long. Its start lies a configured number of ticks before the point at which the trigger was seen. This turns the circular memory into an adjustable delay line placed in front of an event buffer.

For each accepted event, the block also queues a small record that holds the event's word count. A controller drains the data FIFO and the record FIFO at its own pace. It uses pop strobes, empty flags and a live word count to do so. The block admits an event only when the whole window fits in the data FIFO and a record slot is free. Otherwise it raises `busy` and drops the trigger, so a partial event is never written. Both memory depths are parameters and must be powers of two. The event length and the look-back offset come from static configuration inputs.

Top module: `evcap_top`

## Requirements
- R1: Every clock edge after reset stores `din` into the circular memory. Let E be the edge at which `trig_in` is first sampled high, S the offset and N the length. An accepted event then consists of the words sampled at edges E+2-S through E+1-S+N, in that order.
- R2: The event length is `cfg_len` when that value is 3 to 15. Values 0, 1 and 2 give a length of 3.
- R3: A trigger is accepted only if the free space in the data FIFO is at least N words and the record FIFO is not full. A trigger that fails this test writes nothing to either FIFO.
- R4: `busy` is high exactly when the free data space is below the current length or the record FIFO is full. It changes in the same cycle as the pop or configuration change that causes it.
- R5: A trigger pulse that stays high for several clocks produces exactly one event.
- R6: A trigger rising edge that is detected while a copy is in progress is ignored.
- R7: Each accepted event places one record, holding its length N, in the record FIFO. The record becomes visible after the last data word of that event has been written.
- R8: The data and record FIFOs present their head entry directly on `rd_data` and `rec_len`. A pop strobe removes one entry at the clock edge. A pop on an empty FIFO is ignored. `word_count` gives the number of stored data words.
- R9: After reset both FIFOs are empty, `word_count` is 0 and `busy` is low.
- R10: The look-back offset covers the whole range 0 to 255, including the extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one input sample per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 32 | Input stream word |
| trig_in | input | 1 | Asynchronous trigger pulse |
| cfg_len | input | 4 | Words per event (3..15) |
| cfg_shift | input | 8 | Look-back offset in ticks |
| rd_data_pop | input | 1 | Remove head word of the data FIFO |
| rd_data | output | 32 | Head word of the data FIFO |
| data_empty | output | 1 | Data FIFO holds no word |
| rec_pop | input | 1 | Remove head record |
| rec_len | output | 4 | Length field of the head record |
| rec_empty | output | 1 | Record FIFO holds no entry |
| busy | output | 1 | Next trigger would be refused |
| word_count | output | 9 | Words held in the data FIFO |

## Verification
The hardest situations to reach are the two edges of admission: a FIFO that is almost full, and `busy` dropping in the exact cycle that frees space. The bench builds up these states without reading anything back. It overrides the record depth to 32 so that the record FIFO fills first, after 32 three-word events. It then frees the records and fills the data FIFO to 246 words with 15-word events. Next it lowers the length so that `busy` falls with no pop, and tops the FIFO up to 255 words. Finally it pops one word at a time and checks that `busy` falls right after the pop that leaves three free words.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
    localparam int LEN_W   = 4;
    localparam int MIN_LEN = 3;

    typedef enum logic {
        PH_IDLE,
        PH_COPY
    } phase_e;
endpackage

// File: rtl/evcap_ring.sv
// Circular history memory: one write per clock, asynchronous read port.
module evcap_ring #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_d, wptr_q;

    always_comb begin
        wptr_d = wptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wptr_q <= '0;
        else        wptr_q <= wptr_d;
    end

    always_ff @(posedge clk) begin
        mem[wptr_q] <= wr_data;
    end

    assign wr_addr = wptr_q;
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/evcap_fifo.sv
// Synchronous show-ahead FIFO with occupancy count.
module evcap_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  s_d, s_q;
    logic do_push, do_pop;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        empty   = (s_q.cnt == '0);
        full    = (s_q.cnt == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        s_d     = s_q;
        if (do_push) s_d.wptr = s_q.wptr + 1'b1;
        if (do_pop)  s_d.rptr = s_q.rptr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wptr] <= push_data;
    end

    assign pop_data = mem[s_q.rptr];
    assign count    = s_q.cnt;
endmodule

// File: rtl/evcap_ctrl.sv
// Trigger synchroniser, admission test and window copy sequencer.
module evcap_ctrl
    import evcap_pkg::*;
#(
    parameter int RING_DEPTH = 256,
    parameter int EVT_DEPTH  = 256,
    localparam int AW        = $clog2(RING_DEPTH),
    localparam int CW        = $clog2(EVT_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [AW-1:0]    cfg_shift,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CW-1:0]    evt_count,
    input  logic             rec_full,
    output logic [AW-1:0]    rd_addr,
    output logic             data_push,
    output logic             rec_push,
    output logic [LEN_W-1:0] cp_len,
    output logic             busy,
    output logic             copy_active,
    output logic             start_evt
);
    typedef struct packed {
        logic [2:0]       sync;
        phase_e           ph;
        logic [AW-1:0]    rptr;
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] len;
    } st_t;

    st_t s_d, s_q;
    logic [LEN_W-1:0] eff_len;
    logic [CW-1:0]    free_words;
    logic             room, rise;

    always_comb begin
        eff_len    = (cfg_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : cfg_len;
        free_words = CW'(EVT_DEPTH) - evt_count;
        room       = (free_words >= CW'(eff_len)) && !rec_full;
        rise       = s_q.sync[1] && !s_q.sync[2];
        start_evt  = 1'b0;
        s_d        = s_q;
        s_d.sync   = {s_q.sync[1:0], trig_in};
        case (s_q.ph)
            PH_IDLE: begin
                if (rise && room) begin
                    start_evt = 1'b1;
                    s_d.ph    = PH_COPY;
                    s_d.rptr  = wr_addr - cfg_shift;
                    s_d.left  = eff_len;
                    s_d.len   = eff_len;
                end
            end
            default: begin
                s_d.rptr = s_q.rptr + 1'b1;
                s_d.left = s_q.left - 1'b1;
                if (s_q.left == LEN_W'(1)) s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{sync: '0, ph: PH_IDLE, rptr: '0, left: '0, len: '0};
        else        s_q <= s_d;
    end

    assign copy_active = (s_q.ph == PH_COPY);
    assign data_push   = copy_active;
    assign rec_push    = copy_active && (s_q.left == LEN_W'(1));
    assign rd_addr     = s_q.rptr;
    assign cp_len      = s_q.len;
    assign busy        = !room;
endmodule

// File: rtl/evcap_top.sv
module evcap_top
    import evcap_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RING_DEPTH = 256,
    parameter int EVT_DEPTH  = 256,
    parameter int REC_DEPTH  = 128,
    localparam int AW        = $clog2(RING_DEPTH),
    localparam int CW        = $clog2(EVT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              trig_in,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [AW-1:0]     cfg_shift,
    input  logic              rd_data_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_empty,
    input  logic              rec_pop,
    output logic [LEN_W-1:0]  rec_len,
    output logic              rec_empty,
    output logic              busy,
    output logic [CW-1:0]     word_count
);
    localparam int RCW = $clog2(REC_DEPTH + 1);

    logic [AW-1:0]     wr_addr, rd_addr;
    logic [DATA_W-1:0] ring_q;
    logic              data_push, rec_push, rec_full, data_full;
    logic              copy_active, start_evt;
    logic [LEN_W-1:0]  cp_len;
    logic [RCW-1:0]    rec_cnt;

    evcap_ring #(.W(DATA_W), .DEPTH(RING_DEPTH)) ring_i (
        .clk(clk), .rst_n(rst_n), .wr_data(din), .rd_addr(rd_addr),
        .wr_addr(wr_addr), .rd_data(ring_q)
    );

    evcap_ctrl #(.RING_DEPTH(RING_DEPTH), .EVT_DEPTH(EVT_DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_len(cfg_len),
        .cfg_shift(cfg_shift), .wr_addr(wr_addr), .evt_count(word_count),
        .rec_full(rec_full), .rd_addr(rd_addr), .data_push(data_push),
        .rec_push(rec_push), .cp_len(cp_len), .busy(busy),
        .copy_active(copy_active), .start_evt(start_evt)
    );

    evcap_fifo #(.W(DATA_W), .DEPTH(EVT_DEPTH)) data_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(data_push), .push_data(ring_q),
        .pop(rd_data_pop), .pop_data(rd_data), .empty(data_empty),
        .full(data_full), .count(word_count)
    );

    evcap_fifo #(.W(LEN_W), .DEPTH(REC_DEPTH)) rec_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rec_push), .push_data(cp_len),
        .pop(rec_pop), .pop_data(rec_len), .empty(rec_empty),
        .full(rec_full), .count(rec_cnt)
    );
endmodule

// File: rtl/evcap_chk.sv
module evcap_chk #(
    parameter int RING_DEPTH = 256,
    parameter int EVT_DEPTH  = 256,
    parameter int REC_DEPTH  = 128,
    parameter int LEN_W      = 4,
    localparam int AW        = $clog2(RING_DEPTH),
    localparam int CW        = $clog2(EVT_DEPTH + 1),
    localparam int RCW       = $clog2(REC_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    wr_addr,
    input logic [CW-1:0]    word_count,
    input logic             data_full,
    input logic [RCW-1:0]   rec_cnt,
    input logic             data_push,
    input logic             rec_push,
    input logic [LEN_W-1:0] cp_len,
    input logic             copy_active,
    input logic             start_evt
);
    logic [LEN_W:0] push_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)         push_cnt <= '0;
        else if (start_evt) push_cnt <= '0;
        else if (data_push) push_cnt <= push_cnt + 1'b1;
    end

    // R1: history pointer advances on every tick
    p_ring_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> wr_addr == $past(wr_addr) + 1'b1);

    // R3: admission guarantees the data FIFO never receives a word while full
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_push |-> !data_full && (int'(word_count) < EVT_DEPTH));

    // R2: the record length equals the words actually copied, and is at least 3
    p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_push |-> (push_cnt + 1'b1 == {1'b0, cp_len}) && (cp_len >= LEN_W'(3)));

    // R7: record goes in together with the final word and ends the copy
    p_record_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_push |=> !copy_active && $past(data_push));

    // R6: no new event starts while a copy is running
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_active && !rec_push) |=> !start_evt);

    // R8: occupancy moves by at most one word per cycle and stays in range
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (word_count == $past(word_count)) || (word_count == $past(word_count) + 1'b1)
              || (word_count == $past(word_count) - 1'b1));

    p_rec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rec_cnt) <= REC_DEPTH);
endmodule

bind evcap_top evcap_chk #(
    .RING_DEPTH(RING_DEPTH), .EVT_DEPTH(EVT_DEPTH), .REC_DEPTH(REC_DEPTH), .LEN_W(evcap_pkg::LEN_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .word_count(word_count),
    .data_full(data_full), .rec_cnt(rec_cnt), .data_push(data_push),
    .rec_push(rec_push), .cp_len(cp_len), .copy_active(copy_active),
    .start_evt(start_evt)
);

// File: tb/evcap_top_tb_top.sv
`timescale 1ns/1ps
module evcap_top_tb_top;
    localparam int EVT_D = 256;
    localparam int REC_D = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din;
    logic        trig_in = 1'b0;
    logic [3:0]  cfg_len = 4'd3;
    logic [7:0]  cfg_shift = 8'd0;
    logic        rd_data_pop = 1'b0;
    logic [31:0] rd_data;
    logic        data_empty;
    logic        rec_pop = 1'b0;
    logic [3:0]  rec_len;
    logic        rec_empty;
    logic        busy;
    logic [8:0]  word_count;

    int unsigned tick = 0;
    int nchk = 0;
    int nfail = 0;
    int mcount = 0;
    int mrec = 0;
    bit done = 1'b0;
    logic [31:0] dq[$];
    int          rq[$];

    always #5 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    function automatic logic [31:0] pat(int unsigned t);
        return {t[15:0], ~t[15:0]};
    endfunction

    assign din = pat(tick);

    evcap_top #(.EVT_DEPTH(EVT_D), .REC_DEPTH(REC_D)) dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .trig_in(trig_in),
        .cfg_len(cfg_len), .cfg_shift(cfg_shift), .rd_data_pop(rd_data_pop),
        .rd_data(rd_data), .data_empty(data_empty), .rec_pop(rec_pop),
        .rec_len(rec_len), .rec_empty(rec_empty), .busy(busy),
        .word_count(word_count)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: predicts admission and pushes the expected window into the scoreboard.
    task automatic fire(int len, int shift, int width);
        int eff;
        int unsigned t;
        cfg_len   = 4'(len);
        cfg_shift = 8'(shift);
        @(negedge clk);
        eff = (len < 3) ? 3 : len;
        t = tick;
        trig_in = 1'b1;
        if ((EVT_D - mcount >= eff) && (mrec < REC_D)) begin
            for (int i = 0; i < eff; i++) dq.push_back(pat(t + 2 - shift + i));
            rq.push_back(eff);
            mcount += eff;
            mrec++;
        end
        repeat (width) @(negedge clk);
        trig_in = 1'b0;
        repeat (eff + 6) @(negedge clk);
    endtask

    // Monitor: compares the head word with the scoreboard and pops it.
    task automatic take_word(string req);
        check(req, {31'd0, data_empty}, 32'd0);
        check(req, rd_data, dq.pop_front());
        rd_data_pop = 1'b1;
        @(negedge clk);
        rd_data_pop = 1'b0;
        mcount--;
    endtask

    task automatic take_rec(string req);
        check(req, {31'd0, rec_empty}, 32'd0);
        check(req, {28'd0, rec_len}, 32'(rq.pop_front()));
        rec_pop = 1'b1;
        @(negedge clk);
        rec_pop = 1'b0;
        mrec--;
    endtask

    task automatic drain_all(string req);
        while (dq.size() > 0) take_word(req);
        while (rq.size() > 0) take_rec(req);
        check(req, {30'd0, data_empty, rec_empty}, 32'd3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9 empty flags", {30'd0, data_empty, rec_empty}, 32'd3);
        check("R9 word_count", 32'(word_count), 32'd0);
        check("R9 busy", {31'd0, busy}, 32'd0);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);

        // R1: basic window, R7 record
        fire(3, 10, 1);
        check("R1 count after event", 32'(word_count), 32'd3);
        drain_all("R1/R7 basic window");

        // R10: offset extremes, R2 short length clamps to 3
        fire(15, 255, 1);
        check("R10 shift 255 count", 32'(word_count), 32'd15);
        drain_all("R10 shift 255");
        fire(0, 0, 1);
        check("R2 len 0 gives 3", 32'(word_count), 32'd3);
        drain_all("R2/R10 shift 0");

        // R8: pop on empty is ignored
        rd_data_pop = 1'b1;
        rec_pop = 1'b1;
        @(negedge clk);
        rd_data_pop = 1'b0;
        rec_pop = 1'b0;
        check("R8 pop on empty", {22'd0, word_count, data_empty}, 32'd1);
        check("R8 rec pop on empty", {31'd0, rec_empty}, 32'd1);
        fire(7, 40, 1);
        drain_all("R8 after empty pop");

        // R5: wide pulse makes one event
        fire(4, 20, 8);
        check("R5 wide pulse count", 32'(word_count), 32'd4);
        drain_all("R5 wide pulse");

        // R6: second edge during copy ignored
        begin
            int unsigned t;
            cfg_len = 4'd15;
            cfg_shift = 8'd5;
            @(negedge clk);
            t = tick;
            trig_in = 1'b1;
            for (int i = 0; i < 15; i++) dq.push_back(pat(t + 2 - 5 + i));
            rq.push_back(15);
            mcount += 15;
            mrec++;
            @(negedge clk);
            trig_in = 1'b0;
            repeat (3) @(negedge clk);
            trig_in = 1'b1;
            @(negedge clk);
            trig_in = 1'b0;
            repeat (30) @(negedge clk);
            check("R6 retrigger ignored", 32'(word_count), 32'd15);
            drain_all("R6 window");
        end

        // R3/R4: record FIFO fills first
        for (int i = 0; i < REC_D; i++) fire(3, i, 1);
        check("R4 busy on record full", {31'd0, busy}, 32'd1);
        fire(3, 1, 1);
        check("R3 dropped on record full", 32'(word_count), 32'd96);
        while (rq.size() > 0) take_rec("R7 record lengths");
        check("R4 busy clears after records", {31'd0, busy}, 32'd0);

        // R3/R4: data FIFO fills
        for (int i = 0; i < 11; i++) fire(15, 50 + i, 1);
        check("R3 data fill to 246", 32'(word_count), 32'd246);
        check("R4 busy when free below 15", {31'd0, busy}, 32'd1);
        cfg_len = 4'd3;
        @(negedge clk);
        check("R4 busy follows length", {31'd0, busy}, 32'd0);
        for (int i = 0; i < 4; i++) fire(3, 100, 1);
        check("R3 whole events only", 32'(word_count), 32'd255);
        check("R4 busy at 255", {31'd0, busy}, 32'd1);
        take_word("R8 pop one");
        check("R4 busy with 2 free", {31'd0, busy}, 32'd1);
        take_word("R8 pop two");
        check("R4 busy clears with 3 free", {31'd0, busy}, 32'd0);
        drain_all("R1/R8 full drain");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule